// File: doc/BRIEF.md
# Accelerator Control and Power-State Register Block

This block is the control register file of a graphics accelerator. It sits on a simple word-addressed register bus. Writes take effect on the clock edge and reads are combinational. A command register turns each written value into one of nine operations. The block also records which units are powered in four power domains: shader cores, tiler, L2 and L3. Each domain exposes a 64-bit availability mask as two 32-bit halves, along with a ready mask and a power-up and a power-down request word per half.

The cache, counter and power sequencing work is not modelled, so each operation finishes on the clock edge that accepts it and posts its completion cause in an interrupt group. That group has a pending word, a write-one-to-clear word, an enable mask and a masked view. A single interrupt line is high while any enabled cause is pending. The two reset commands return the block's state to its reset values, pulse a reset strobe to the rest of the accelerator, and leave the reset-done cause pending. The availability masks are fixed by a parameter and are never affected.

Word addresses: 0x00 pending causes (read), 0x01 cause clear (write), 0x02 enable mask (read/write), 0x03 masked causes (read), 0x04 command (write). Power words sit at 0x10 + 8*domain + 2*kind + half, where domain is 0 shader, 1 tiler, 2 L2, 3 L3; kind is 0 availability, 1 ready, 2 power-up, 3 power-down; and half is 0 low, 1 high.

Top module: `accel_ctrl_regs`

## Requirements
- R1: Command values 0, 3, 5 and 6 written to address 0x04 change no readable word, the interrupt line and the reset strobe.
- R2: A command value of 9 or above written to address 0x04 is ignored: no readable word, interrupt line or reset strobe changes.
- R3: Command 1 or 2 at address 0x04 drives the reset strobe high for the one cycle after the write. It clears every ready word and the enable mask, and leaves the pending word exactly equal to bit 8 (reset done).
- R4: Command 4 at address 0x04 sets pending bit 16 (sample done).
- R5: Commands 7 and 8 at address 0x04 both set pending bit 17 (cache clean done).
- R6: A write to a power-up word (0x10 + 8*domain + 4 + half) ORs the written value, ANDed with the availability half of the same domain and half, into the ready half of the same domain and half. A ready bit is never set where availability is 0.
- R7: A write to a power-down word (0x10 + 8*domain + 6 + half) clears every bit of the ready half of the same domain and half that is 1 in the written value.
- R8: Every power-up or power-down write sets pending bits 9 and 10 together.
- R9: Writing to 0x01 clears the pending bits that are 1 in the written value. Writes to 0x00 and 0x03 are ignored.
- R10: The enable mask at 0x02 reads back what was written. Address 0x03 reads as pending AND mask, and the interrupt line is high exactly when that value is non-zero.
- R11: Availability words read the parameter value and ignore writes. Power-up, power-down, clear, command and unmapped addresses read 0, and writes to unmapped addresses are ignored.
- R12: After reset the ready words, pending word and enable mask are zero, and the interrupt line and reset strobe are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt, high while any enabled cause is pending |
| soft_rst_o | output | 1 | One-cycle reset strobe after a reset command |

## Verification
On every cycle the assertions check several properties. No ready bit is outside availability. A power-down write leaves none of its bits ready, and a power-up write never drops a ready bit. A power write always posts both power-changed causes, and a clear write removes its bits from the pending word. A reset command leaves exactly the reset-done cause pending with the mask zero, and the strobe only follows a reset command. The bench scenarios show the rest: that the no-op, counter and out-of-range commands change nothing readable, that the low and high halves pair correctly across all four domains, and that read-only and unmapped addresses return the right values after mixed traffic.

// File: rtl/accel_ctrl_pkg.sv
`timescale 1ns/1ps
package accel_ctrl_pkg;

  localparam int WORD_W = 32;

  // word addresses of the control group
  localparam int A_RAW      = 0;
  localparam int A_CLR      = 1;
  localparam int A_MASK     = 2;
  localparam int A_STAT     = 3;
  localparam int A_CMD      = 4;
  localparam int A_PWR_BASE = 16;
  localparam int PWR_STRIDE = 8;

  // interrupt cause positions
  localparam int IRQ_RESET_DONE  = 8;
  localparam int IRQ_PWR_ONE     = 9;
  localparam int IRQ_PWR_ALL     = 10;
  localparam int IRQ_SAMPLE_DONE = 16;
  localparam int IRQ_CLEAN_DONE  = 17;

  localparam int CMD_COUNT = 9;

  typedef enum logic [3:0] {
    CMD_NOP        = 4'd0,
    CMD_SOFT_RST   = 4'd1,
    CMD_HARD_RST   = 4'd2,
    CMD_CNT_CLR    = 4'd3,
    CMD_CNT_SAMPLE = 4'd4,
    CMD_CYC_START  = 4'd5,
    CMD_CYC_STOP   = 4'd6,
    CMD_CLEAN      = 4'd7,
    CMD_CLEAN_INV  = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    PK_AVAIL = 2'd0,
    PK_READY = 2'd1,
    PK_UP    = 2'd2,
    PK_DOWN  = 2'd3
  } pwr_kind_e;

  typedef struct packed {
    logic wipe;
    logic sample;
    logic clean;
  } cmd_evt_t;

endpackage

// File: rtl/accel_rst_sync.sv
`timescale 1ns/1ps
module accel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/accel_cmd_decode.sv
`timescale 1ns/1ps
module accel_cmd_decode
  import accel_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_val,
  output cmd_evt_t          evt
);

  logic  in_range;
  cmd_e  cmd_code;

  assign in_range = (cmd_val < WORD_W'(CMD_COUNT));
  assign cmd_code = cmd_e'(cmd_val[3:0]);

  always_comb begin
    evt = '0;
    if (cmd_wr && in_range) begin
      unique case (cmd_code)
        CMD_SOFT_RST, CMD_HARD_RST: evt.wipe   = 1'b1;
        CMD_CNT_SAMPLE:             evt.sample = 1'b1;
        CMD_CLEAN, CMD_CLEAN_INV:   evt.clean  = 1'b1;
        default:                    evt        = '0;
      endcase
    end
  end

  // R2
  high_cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !in_range) |-> (evt == '0));

  // R1
  single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt));

endmodule

// File: rtl/accel_pwr_word.sv
`timescale 1ns/1ps
module accel_pwr_word #(
  parameter int          W     = 32,
  parameter logic [W-1:0] AVAIL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic         up_wr,
  input  logic         down_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ready
);

  logic [W-1:0] ready_q;
  logic [W-1:0] ready_nxt;
  logic         ready_en;

  assign ready_en = wipe | up_wr | down_wr;

  always_comb begin
    ready_nxt = ready_q;
    if (wipe)         ready_nxt = '0;
    else if (up_wr)   ready_nxt = ready_q | (wdata & AVAIL);
    else if (down_wr) ready_nxt = ready_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ready_q <= '0;
    else if (ready_en) ready_q <= ready_nxt;
  end

  assign ready = ready_q;

  // R6
  ready_in_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q & ~AVAIL) == '0);

  // R6
  up_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_wr |=> ((ready_q & $past(ready_q)) == $past(ready_q)));

  // R7
  down_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    down_wr |=> ((ready_q & $past(wdata)) == '0));

endmodule

// File: rtl/accel_irq_group.sv
`timescale 1ns/1ps
module accel_irq_group
  import accel_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic [WORD_W-1:0] set_bits,
  input  logic              clr_wr,
  input  logic              mask_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] raw,
  output logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] status,
  output logic              irq
);

  localparam logic [WORD_W-1:0] RESET_ONLY = WORD_W'(1) << IRQ_RESET_DONE;

  logic [WORD_W-1:0] raw_q, raw_nxt, mask_q, mask_nxt, clr_bits;
  logic              raw_en, mask_en;

  assign clr_bits = clr_wr ? wdata : '0;
  assign raw_en   = wipe | clr_wr | (|set_bits);
  assign mask_en  = wipe | mask_wr;

  always_comb begin
    if (wipe) raw_nxt = set_bits;
    else      raw_nxt = (raw_q & ~clr_bits) | set_bits;
  end

  always_comb begin
    if (wipe)         mask_nxt = '0;
    else if (mask_wr) mask_nxt = wdata;
    else              mask_nxt = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_nxt;
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign status = raw_q & mask_q;
  assign irq    = |status;

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((raw_q & $past(wdata)) == '0));

  // R3
  wipe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (raw_q == RESET_ONLY && mask_q == '0));

  // R10
  enabled_cause_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(set_bits & mask_q)) && !wipe && !mask_wr) |=> irq);

endmodule

// File: rtl/accel_ctrl_regs.sv
`timescale 1ns/1ps
module accel_ctrl_regs
  import accel_ctrl_pkg::*;
#(
  parameter int                  N_DOM       = 4,
  parameter int                  ADDR_W      = 6,
  parameter logic [N_DOM*64-1:0] PRESENT_MAP = {64'h0000_0000_0000_0000,
                                                64'h0000_0001_0000_0003,
                                                64'h0000_0000_0000_0001,
                                                64'h0000_000F_0000_00FF}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              soft_rst_o
);

  localparam int N_WORDS = 2 * N_DOM;
  localparam int PWR_END = A_PWR_BASE + PWR_STRIDE * N_DOM;
  localparam int IDX_W   = ADDR_W - 2;

  logic              rst_sync_n;
  cmd_evt_t          evt;
  logic              cmd_wr, clr_wr, mask_wr, pwr_any_wr;
  logic [N_WORDS-1:0] up_vec, down_vec;
  logic [WORD_W-1:0] ready_w [N_WORDS];
  logic [WORD_W-1:0] set_bits, raw, mask, status;
  logic              soft_q;

  logic              in_pwr;
  logic [ADDR_W-1:0] pw_off;
  logic [IDX_W-1:0]  pw_idx;
  pwr_kind_e         pw_kind;

  accel_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cmd_wr  = bus_wr && (bus_addr == ADDR_W'(A_CMD));
  assign clr_wr  = bus_wr && (bus_addr == ADDR_W'(A_CLR));
  assign mask_wr = bus_wr && (bus_addr == ADDR_W'(A_MASK));

  accel_cmd_decode u_cmd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd_wr  (cmd_wr),
    .cmd_val (bus_wdata),
    .evt     (evt)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int UP_A   = A_PWR_BASE + PWR_STRIDE*d + 2*int'(PK_UP) + h;
      localparam int DOWN_A = A_PWR_BASE + PWR_STRIDE*d + 2*int'(PK_DOWN) + h;
      localparam int IDX    = 2*d + h;

      assign up_vec[IDX]   = bus_wr && (bus_addr == ADDR_W'(UP_A));
      assign down_vec[IDX] = bus_wr && (bus_addr == ADDR_W'(DOWN_A));

      accel_pwr_word #(
        .W     (WORD_W),
        .AVAIL (PRESENT_MAP[IDX*WORD_W +: WORD_W])
      ) u_word (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .wipe    (evt.wipe),
        .up_wr   (up_vec[IDX]),
        .down_wr (down_vec[IDX]),
        .wdata   (bus_wdata),
        .ready   (ready_w[IDX])
      );
    end
  end

  assign pwr_any_wr = (|up_vec) | (|down_vec);

  always_comb begin
    set_bits = '0;
    set_bits[IRQ_RESET_DONE]  = evt.wipe;
    set_bits[IRQ_SAMPLE_DONE] = evt.sample;
    set_bits[IRQ_CLEAN_DONE]  = evt.clean;
    set_bits[IRQ_PWR_ONE]     = pwr_any_wr;
    set_bits[IRQ_PWR_ALL]     = pwr_any_wr;
  end

  accel_irq_group u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wipe     (evt.wipe),
    .set_bits (set_bits),
    .clr_wr   (clr_wr),
    .mask_wr  (mask_wr),
    .wdata    (bus_wdata),
    .raw      (raw),
    .mask     (mask),
    .status   (status),
    .irq      (irq_o)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) soft_q <= 1'b0;
    else             soft_q <= evt.wipe;
  end

  assign soft_rst_o = soft_q;

  // read path
  assign in_pwr  = (bus_addr >= ADDR_W'(A_PWR_BASE)) && (bus_addr < ADDR_W'(PWR_END));
  assign pw_off  = bus_addr - ADDR_W'(A_PWR_BASE);
  assign pw_idx  = {pw_off[ADDR_W-1:3], pw_off[0]};
  assign pw_kind = pwr_kind_e'(pw_off[2:1]);

  always_comb begin
    bus_rdata = '0;
    if (in_pwr) begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (pw_idx == IDX_W'(i)) begin
          if (pw_kind == PK_AVAIL)      bus_rdata = PRESENT_MAP[i*WORD_W +: WORD_W];
          else if (pw_kind == PK_READY) bus_rdata = ready_w[i];
        end
      end
    end else begin
      unique case (bus_addr)
        ADDR_W'(A_RAW):  bus_rdata = raw;
        ADDR_W'(A_MASK): bus_rdata = mask;
        ADDR_W'(A_STAT): bus_rdata = status;
        default:         bus_rdata = '0;
      endcase
    end
  end

  // R8
  pwr_write_posts_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pwr_any_wr |=> (raw[IRQ_PWR_ONE] && raw[IRQ_PWR_ALL]));

  // R3
  strobe_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst_o |-> $past(bus_wr && bus_addr == ADDR_W'(A_CMD) &&
                         (bus_wdata == 32'd1 || bus_wdata == 32'd2)));

endmodule

// File: tb/accel_ctrl_regs_bench.sv
`timescale 1ns/1ps
module accel_ctrl_regs_bench;

  localparam int N_DOM  = 4;
  localparam int ADDR_W = 6;
  localparam logic [N_DOM*64-1:0] PMAP = {64'h0000_0000_0000_0000,
                                          64'h0000_0001_0000_0003,
                                          64'h0000_0000_0000_0001,
                                          64'h0000_000F_0000_00FF};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              irq_o;
  logic              soft_rst_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_ready [8];
  logic [31:0] m_raw, m_mask;
  logic        m_soft;

  always #2 clk = ~clk;

  accel_ctrl_regs #(.N_DOM(N_DOM), .ADDR_W(ADDR_W), .PRESENT_MAP(PMAP)) u_accel_ctrl_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_o      (irq_o),
    .soft_rst_o (soft_rst_o)
  );

  function automatic logic [31:0] avail(input int idx);
    return PMAP[idx*32 +: 32];
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    int off, idx, kind;
    if (a == 0) return m_raw;
    if (a == 2) return m_mask;
    if (a == 3) return m_raw & m_mask;
    if (a >= 16 && a < 48) begin
      off  = a - 16;
      idx  = (off / 8) * 2 + (off % 2);
      kind = (off / 2) % 4;
      if (kind == 0) return avail(idx);
      if (kind == 1) return m_ready[idx];
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(input int a);
    int kind;
    if (a == 0 || a == 1) return "R9";
    if (a == 2 || a == 3) return "R10";
    if (a >= 16 && a < 48) begin
      kind = ((a - 16) / 2) % 4;
      if (kind == 0) return "R11";
      if (kind == 1) return "R6/R7";
    end
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // model of one accepted write
  function automatic void model_write(input int a, input logic [31:0] d);
    int off, idx, kind;
    m_soft = 1'b0;
    if (a == 1) m_raw = m_raw & ~d;
    else if (a == 2) m_mask = d;
    else if (a == 4) begin
      if (d == 1 || d == 2) begin
        for (int i = 0; i < 8; i++) m_ready[i] = '0;
        m_mask = '0;
        m_raw  = 32'h0000_0100;
        m_soft = 1'b1;
      end else if (d == 4) m_raw[16] = 1'b1;
      else if (d == 7 || d == 8) m_raw[17] = 1'b1;
    end else if (a >= 16 && a < 48) begin
      off  = a - 16;
      idx  = (off / 8) * 2 + (off % 2);
      kind = (off / 2) % 4;
      if (kind == 2) begin
        m_ready[idx] = m_ready[idx] | (d & avail(idx));
        m_raw[10:9] = 2'b11;
      end else if (kind == 3) begin
        m_ready[idx] = m_ready[idx] & ~d;
        m_raw[10:9] = 2'b11;
      end
    end
  endfunction

  task automatic sweep(input string ctx);
    logic [31:0] v;
    for (int a = 0; a < 64; a++) begin
      bus_addr = ADDR_W'(a);
      #0.05;
      v = bus_rdata;
      check($sformatf("%s %s addr %0d", ctx, tag_of(a), a), v, exp_read(a));
    end
    check($sformatf("%s R10 irq", ctx), {31'b0, irq_o}, {31'b0, |(m_raw & m_mask)});
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input string ctx);
    bus_wr    = 1'b1;
    bus_addr  = ADDR_W'(a);
    bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
    check($sformatf("%s R3 strobe", ctx), {31'b0, soft_rst_o}, {31'b0, m_soft});
    sweep(ctx);
    @(negedge clk);
    if (m_soft) check($sformatf("%s R3 strobe width", ctx), {31'b0, soft_rst_o}, 32'h0);
  endtask

  function automatic string cmd_tag(input logic [31:0] d);
    if (d >= 9) return "R2";
    if (d == 1 || d == 2) return "R3";
    if (d == 4) return "R4";
    if (d == 7 || d == 8) return "R5";
    return "R1";
  endfunction

  function automatic int pwr_addr(input int dom, input int kind, input int half);
    return 16 + 8*dom + 2*kind + half;
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int a, sel;
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < 8; i++) m_ready[i] = '0;
    m_raw = '0; m_mask = '0; m_soft = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 strobe", {31'b0, soft_rst_o}, 32'h0);
    sweep("R12 reset");

    // R6 every half of every domain, all ones: masked by availability
    for (int dm = 0; dm < N_DOM; dm++)
      for (int h = 0; h < 2; h++)
        do_write(pwr_addr(dm, 2, h), 32'hFFFF_FFFF, "R6 up all");
    // R10 enable everything, R8 power causes visible
    do_write(2, 32'hFFFF_FFFF, "R10 mask");
    // R7 partial power-down of shader low half
    do_write(pwr_addr(0, 3, 0), 32'h0000_00F0, "R7 down");
    // R11 availability and unmapped writes ignored
    do_write(pwr_addr(0, 0, 0), 32'h0, "R11 avail wr");
    do_write(pwr_addr(2, 0, 1), 32'h0, "R11 avail wr");
    do_write(5, 32'hFFFF_FFFF, "R11 unmapped");
    do_write(63, 32'hFFFF_FFFF, "R11 unmapped");
    // R9 writes to pending / masked views ignored, then clear
    do_write(0, 32'h0, "R9 raw wr");
    do_write(3, 32'h0, "R9 stat wr");
    do_write(1, 32'h0000_0200, "R9 clear one");
    // every command value and some out-of-range ones
    for (int c = 0; c < 9; c++) begin
      do_write(4, 32'(c), $sformatf("%s cmd %0d", cmd_tag(32'(c)), c));
      do_write(2, 32'hFFFF_FFFF, "R10 mask");
      do_write(pwr_addr(1, 2, 0), 32'h1, "R6 up");
    end
    do_write(4, 32'd9, "R2 cmd 9");
    do_write(4, 32'hFFFF_FFFF, "R2 cmd max");
    do_write(4, 32'h0000_0011, "R2 cmd 17");

    // random mix
    for (int n = 0; n < 500; n++) begin
      sel = int'($urandom % 10);
      d   = $urandom;
      if (sel < 3) begin
        a = 4;
        if ($urandom % 4 != 0) d = 32'($urandom % 12);
      end else if (sel < 7) a = 16 + int'($urandom % 32);
      else if (sel == 7) a = 1;
      else if (sel == 8) a = 2;
      else a = int'($urandom % 64);
      do_write(a, d, (a == 4) ? $sformatf("%s rnd cmd %0d", cmd_tag(d), d)
                              : $sformatf("%s rnd", tag_of(a)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule